// File: doc/BRIEF.md
# Reset Strap Capture and GPIO Pin Ownership Unit

This block sits between a chip's pad ring and its internal functions for a group of multi-function pins. While the system reset is held, every pin it controls is left undriven so that board pull resistors set the level on seven configuration-capable pins and on three bonding pins. On reset release the unit records those levels once. It keeps them until the next reset release, and uses them to decide which shared pins belong to general-purpose I/O and which to a dedicated interface.

Nine GPIO bits each have a direction bit, an output bit and a synchronised input read-back, and each has its own reset default. Bits that a strap gives to an alternate function (a third audio ADC port on bits 5 to 8, a slave two-wire port on bits 3 and 4) take their drive and enable from that function, and register writes to them are dropped. A strap also steers one shared serial input either to an AC-link receiver or to an ADC. Another strap optionally delays the EEPROM chip select by one clock. One control bit sets the polarity of the external codec reset pin.

A three-phase sequencer controls the unit. HOLD is forced while reset is low. SAMPLE lasts exactly one clock after release, and the strap registers load on the edge that leaves it. RUN is then held until the next reset. The transitions are HOLD→SAMPLE on the first clock with reset high, SAMPLE→RUN unconditionally, and any phase→HOLD asynchronously on reset.

Top module: `strap_gpio_mux`

## Requirements
- R1: While rst_n is low, and during the single SAMPLE clock after its release, cfg_pin_oe and gpio_pin_oe are all zero. In RUN, cfg_pin_oe is all ones.
- R2: On the clock edge that ends SAMPLE, strap_o takes the value of cfg_pin_i. Bit 0 is the ADC3 select, bit 1 the shared-input select, bit 2 the GPIO3/4 select, bits 5:3 the codec ID and bit 6 the chip-select delay. strap_o then holds that value until a later reset release, whatever cfg_pin_i does.
- R3: When strap bit 0 is 1, GPIO bits 5 to 8 are driven from alt_out_i and enabled from alt_oe_i. When it is 0, those bits are general-purpose.
- R4: When strap bit 2 is 0, GPIO bits 3 and 4 are driven and enabled from the alternate inputs. When it is 1, they are general-purpose.
- R5: In RUN, when strap bit 1 is 1, shared_sdi_i drives aclink_sdi1_o and adc1_sdin1_o is 0. When strap bit 1 is 0, the routing is the reverse.
- R6: cfg_pin_o bit 6 (EEPROM chip select) follows cfg_func_i bit 6 combinationally when strap bit 6 is 0, and one clock later when it is 1. cfg_pin_o bits 0 to 5 follow cfg_func_i directly.
- R7: After reset, every general-purpose bit is output-enabled according to 9'h0AB (bits 0, 1, 3, 5 and 7 are outputs), and it drives 0.
- R8: In RUN, a write with wr_sel_i=0 loads the direction bits (1 = output), and a write with wr_sel_i=1 loads the output bits. Bits owned by an alternate function are left unchanged and the pin does not follow the write.
- R9: gpio_rd_o shows gpio_pin_i after two clock edges.
- R10: A write with wr_sel_i=2 loads wr_data_i bit 0 as the codec reset polarity, which resets to 0. With polarity 0, codec_rst_pin_o is the inverse of codec_rst_req_i. With polarity 1, it equals codec_rst_req_i.
- R11: bond_id_o takes bond_pin_i on the same edge as strap_o and holds it in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_pin_i | input | 7 | Levels of the configuration-capable pins |
| cfg_func_i | input | 7 | Function drive for those pins in RUN |
| cfg_pin_o | output | 7 | Drive of the configuration-capable pins |
| cfg_pin_oe | output | 7 | Output enable of those pins |
| bond_pin_i | input | 3 | Bonding option levels |
| gpio_pin_i | input | 9 | GPIO pad levels |
| alt_out_i | input | 9 | Alternate-function drive per GPIO pin |
| alt_oe_i | input | 9 | Alternate-function enable per GPIO pin |
| gpio_pin_o | output | 9 | GPIO pad drive |
| gpio_pin_oe | output | 9 | GPIO pad output enable |
| gpio_rd_o | output | 9 | Synchronised GPIO input read-back |
| shared_sdi_i | input | 1 | Shared serial data input pad |
| aclink_sdi1_o | output | 1 | Shared input routed to the AC-link receiver |
| adc1_sdin1_o | output | 1 | Shared input routed to ADC 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 direction, 1 output, 2 control |
| wr_data_i | input | 9 | Write data |
| codec_rst_req_i | input | 1 | Internal codec reset request |
| codec_rst_pin_o | output | 1 | External codec reset pin |
| strap_o | output | 7 | Latched strap vector |
| bond_id_o | output | 3 | Latched bonding ID |

## Verification
The main pattern is a sweep through all 128 strap vectors, each applied through a full reset. For every vector the bench checks the latched value, the pin ownership of all nine GPIO bits against an asymmetric alternate-function pattern, the routing of the shared input and the chip-select timing. This separates the independent strap bits from one another, and it would expose a swapped or inverted select. Changing the strap pins after capture shows that the latch is a one-time load rather than a live path. Directed sequences follow. They cover the default directions with every bit general-purpose, full writes compared with writes masked by ownership, a sample of the synchroniser one edge early and on time, and both codec reset polarities.

// File: rtl/strap_gpio_pkg.sv
package strap_gpio_pkg;

    localparam int CFG_W  = 7;
    localparam int GPIO_W = 9;
    localparam int BOND_W = 3;

    localparam int SB_ADC3    = 0;
    localparam int SB_SDI_SEL = 1;
    localparam int SB_GPIO34  = 2;
    localparam int SB_CID_LO  = 3;
    localparam int SB_EE_DLY  = 6;

    localparam logic [GPIO_W-1:0] DIR_RESET = 9'h0AB;
    localparam logic [GPIO_W-1:0] ADC3_BITS = 9'h1E0;
    localparam logic [GPIO_W-1:0] SLV_BITS  = 9'h018;

    localparam logic [1:0] SEL_DIR = 2'd0;
    localparam logic [1:0] SEL_OUT = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_RUN    = 2'd2
    } phase_e;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strap_gpio_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int BW = BOND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_pin_i,
    input  logic [BW-1:0] bond_pin_i,
    output phase_e        phase_o,
    output logic [CW-1:0] strap_o,
    output logic [BW-1:0] bond_o
);

    phase_e state_q;
    phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Capture registers are deliberately not cleared by reset so that the
    // recorded configuration survives until the next release.
    always_ff @(posedge clk) begin
        if (state_q == ST_SAMPLE) begin
            strap_o <= cfg_pin_i;
            bond_o  <= bond_pin_i;
        end
    end

    assign phase_o = state_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import strap_gpio_pkg::*;
#(
    parameter int W           = GPIO_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] lock_i,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] out_o,
    output logic         pol_o,
    output logic [W-1:0] rd_o
);

    logic [W-1:0] sync_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o <= DIR_RESET[W-1:0];
            out_o <= '0;
            pol_o <= 1'b0;
        end else if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_DIR: dir_o <= (dir_o & lock_i) | (wr_data_i & ~lock_i);
                SEL_OUT: out_o <= (out_o & lock_i) | (wr_data_i & ~lock_i);
                SEL_CTL: pol_o <= wr_data_i[0];
                default: ;
            endcase
        end
    end

    generate
        for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_sync
            if (st == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[st] <= '0;
                    else        sync_q[st] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[st] <= '0;
                    else        sync_q[st] <= sync_q[st-1];
                end
            end
        end
    endgenerate

    assign rd_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import strap_gpio_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int W  = GPIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_i,
    input  logic          sdi_sel_i,
    input  logic          ee_dly_i,
    input  logic [W-1:0]  own_i,
    input  logic [W-1:0]  dir_i,
    input  logic [W-1:0]  out_i,
    input  logic          pol_i,
    input  logic [W-1:0]  alt_out_i,
    input  logic [W-1:0]  alt_oe_i,
    input  logic [CW-1:0] cfg_func_i,
    input  logic          shared_sdi_i,
    input  logic          codec_rst_req_i,
    output logic [CW-1:0] cfg_pin_o,
    output logic [CW-1:0] cfg_pin_oe,
    output logic [W-1:0]  gpio_pin_o,
    output logic [W-1:0]  gpio_pin_oe,
    output logic          aclink_sdi1_o,
    output logic          adc1_sdin1_o,
    output logic          codec_rst_pin_o
);

    logic run;
    logic ee_cs_q;

    assign run = (phase_i == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ee_cs_q <= 1'b0;
        else        ee_cs_q <= cfg_func_i[CW-1];
    end

    always_comb begin
        cfg_pin_o         = cfg_func_i;
        cfg_pin_o[CW-1]   = ee_dly_i ? ee_cs_q : cfg_func_i[CW-1];
        cfg_pin_oe        = {CW{run}};
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            always_comb begin
                if (own_i[b]) begin
                    gpio_pin_o[b]  = alt_out_i[b];
                    gpio_pin_oe[b] = run & alt_oe_i[b];
                end else begin
                    gpio_pin_o[b]  = out_i[b];
                    gpio_pin_oe[b] = run & dir_i[b];
                end
            end
        end
    endgenerate

    assign aclink_sdi1_o   = run &  sdi_sel_i & shared_sdi_i;
    assign adc1_sdin1_o    = run & ~sdi_sel_i & shared_sdi_i;
    assign codec_rst_pin_o = pol_i ? codec_rst_req_i : ~codec_rst_req_i;

endmodule

// File: rtl/strap_gpio_mux.sv
module strap_gpio_mux
    import strap_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_pin_i,
    input  logic [CFG_W-1:0]  cfg_func_i,
    output logic [CFG_W-1:0]  cfg_pin_o,
    output logic [CFG_W-1:0]  cfg_pin_oe,
    input  logic [BOND_W-1:0] bond_pin_i,
    input  logic [GPIO_W-1:0] gpio_pin_i,
    input  logic [GPIO_W-1:0] alt_out_i,
    input  logic [GPIO_W-1:0] alt_oe_i,
    output logic [GPIO_W-1:0] gpio_pin_o,
    output logic [GPIO_W-1:0] gpio_pin_oe,
    output logic [GPIO_W-1:0] gpio_rd_o,
    input  logic              shared_sdi_i,
    output logic              aclink_sdi1_o,
    output logic              adc1_sdin1_o,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [GPIO_W-1:0] wr_data_i,
    input  logic              codec_rst_req_i,
    output logic              codec_rst_pin_o,
    output logic [CFG_W-1:0]  strap_o,
    output logic [BOND_W-1:0] bond_id_o
);

    phase_e            phase_w;
    logic [CFG_W-1:0]  strap_w;
    logic [GPIO_W-1:0] own_w;
    logic [GPIO_W-1:0] lock_w;
    logic [GPIO_W-1:0] dir_w;
    logic [GPIO_W-1:0] out_w;
    logic              pol_w;
    logic              run_w;

    strap_latch #(.CW(CFG_W), .BW(BOND_W)) i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_pin_i  (cfg_pin_i),
        .bond_pin_i (bond_pin_i),
        .phase_o    (phase_w),
        .strap_o    (strap_w),
        .bond_o     (bond_id_o)
    );

    assign run_w = (phase_w == ST_RUN);
    assign own_w = ({GPIO_W{strap_w[SB_ADC3]}}    & ADC3_BITS)
                 | ({GPIO_W{~strap_w[SB_GPIO34]}} & SLV_BITS);
    // Before RUN every bit is locked so no write lands on an unknown mask.
    assign lock_w = run_w ? own_w : {GPIO_W{1'b1}};

    gpio_regs #(.W(GPIO_W), .SYNC_STAGES(2)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .lock_i    (lock_w),
        .pin_i     (gpio_pin_i),
        .dir_o     (dir_w),
        .out_o     (out_w),
        .pol_o     (pol_w),
        .rd_o      (gpio_rd_o)
    );

    pin_mux #(.CW(CFG_W), .W(GPIO_W)) i_mux (
        .clk             (clk),
        .rst_n           (rst_n),
        .phase_i         (phase_w),
        .sdi_sel_i       (strap_w[SB_SDI_SEL]),
        .ee_dly_i        (strap_w[SB_EE_DLY]),
        .own_i           (lock_w),
        .dir_i           (dir_w),
        .out_i           (out_w),
        .pol_i           (pol_w),
        .alt_out_i       (alt_out_i),
        .alt_oe_i        (alt_oe_i),
        .cfg_func_i      (cfg_func_i),
        .shared_sdi_i    (shared_sdi_i),
        .codec_rst_req_i (codec_rst_req_i),
        .cfg_pin_o       (cfg_pin_o),
        .cfg_pin_oe      (cfg_pin_oe),
        .gpio_pin_o      (gpio_pin_o),
        .gpio_pin_oe     (gpio_pin_oe),
        .aclink_sdi1_o   (aclink_sdi1_o),
        .adc1_sdin1_o    (adc1_sdin1_o),
        .codec_rst_pin_o (codec_rst_pin_o)
    );

    assign strap_o = strap_w;

endmodule

// File: rtl/strap_gpio_checker.sv
module strap_gpio_checker
    import strap_gpio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CFG_W-1:0]  strap,
    input logic [CFG_W-1:0]  cfg_func,
    input logic [CFG_W-1:0]  cfg_out,
    input logic [CFG_W-1:0]  cfg_oe,
    input logic [GPIO_W-1:0] pin_i,
    input logic [GPIO_W-1:0] alt_out,
    input logic [GPIO_W-1:0] alt_oe,
    input logic [GPIO_W-1:0] pin_o,
    input logic [GPIO_W-1:0] pin_oe,
    input logic [GPIO_W-1:0] rd
);

    // R1
    a_r1_hiz_in_reset: assert property (@(posedge clk)
        !rst_n |-> (cfg_oe == '0 && pin_oe == '0));

    // R2
    a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(strap));

    // R3
    a_r3_adc3_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (run && strap[SB_ADC3]) |-> (pin_o[8:5] == alt_out[8:5]));

    // R4
    a_r4_slave_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !strap[SB_GPIO34]) |-> (pin_oe[4:3] == alt_oe[4:3]));

    // R6
    a_r6_ee_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && strap[SB_EE_DLY]) |->
        (cfg_out[CFG_W-1] == $past(cfg_func[CFG_W-1])));

    // R9
    a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (rd == $past(pin_i, 2)));

endmodule

bind strap_gpio_mux strap_gpio_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .strap    (strap_w),
    .cfg_func (cfg_func_i),
    .cfg_out  (cfg_pin_o),
    .cfg_oe   (cfg_pin_oe),
    .pin_i    (gpio_pin_i),
    .alt_out  (alt_out_i),
    .alt_oe   (alt_oe_i),
    .pin_o    (gpio_pin_o),
    .pin_oe   (gpio_pin_oe),
    .rd       (gpio_rd_o)
);

// File: tb/test_strap_gpio_mux.sv
module test_strap_gpio_mux;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] ALT_OE  = 9'h155;
    localparam logic [8:0] ALT_OUT = 9'h0F3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_pin_i = '0;
    logic [6:0] cfg_func_i = '0;
    logic [6:0] cfg_pin_o, cfg_pin_oe;
    logic [2:0] bond_pin_i = '0;
    logic [8:0] gpio_pin_i = '0;
    logic [8:0] alt_out_i = '0;
    logic [8:0] alt_oe_i = '0;
    logic [8:0] gpio_pin_o, gpio_pin_oe, gpio_rd_o;
    logic       shared_sdi_i = 1'b0;
    logic       aclink_sdi1_o, adc1_sdin1_o;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [8:0] wr_data_i = '0;
    logic       codec_rst_req_i = 1'b0;
    logic       codec_rst_pin_o;
    logic [6:0] strap_o;
    logic [2:0] bond_id_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_gpio_mux i_strap_gpio_mux (.*);

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [6:0] s, input logic [2:0] b);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pin_i = s;
        bond_pin_i = b;
        @(negedge clk);
        @(negedge clk);
        check(cfg_pin_oe == 0 && gpio_pin_oe == 0, "R1 reset",
              {cfg_pin_oe, gpio_pin_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_pin_oe == 0 && gpio_pin_oe == 0, "R1 sample",
              {cfg_pin_oe, gpio_pin_oe}, 0);
        @(negedge clk);
        cfg_pin_i = ~s;
        bond_pin_i = ~b;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [8:0] d);
        wr_en_i = 1'b1;
        wr_sel_i = sel;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] own, exp_oe, exp_out;
        alt_oe_i = ALT_OE;
        alt_out_i = ALT_OUT;
        shared_sdi_i = 1'b1;

        // Sweep every strap combination
        for (int s = 0; s < 128; s++) begin
            logic [6:0] sv;
            logic [2:0] bv;
            sv = s[6:0];
            bv = s[2:0] ^ 3'b101;
            do_reset(sv, bv);
            @(negedge clk);
            check(strap_o == sv, "R2 capture", strap_o, sv);
            check(bond_id_o == bv, "R11 bond", bond_id_o, bv);
            check(cfg_pin_oe == 7'h7F, "R1 run enable", cfg_pin_oe, 7'h7F);
            own = (sv[0] ? 9'h1E0 : 9'h000) | (sv[2] ? 9'h000 : 9'h018);
            exp_oe  = (ALT_OE & own) | (9'h0AB & ~own);
            exp_out = ALT_OUT & own;
            check(gpio_pin_oe[8:5] == exp_oe[8:5] && gpio_pin_o[8:5] == exp_out[8:5],
                  "R3 adc3 ownership", {gpio_pin_oe[8:5], gpio_pin_o[8:5]},
                  {exp_oe[8:5], exp_out[8:5]});
            check(gpio_pin_oe[4:3] == exp_oe[4:3] && gpio_pin_o[4:3] == exp_out[4:3],
                  "R4 slave ownership", {gpio_pin_oe[4:3], gpio_pin_o[4:3]},
                  {exp_oe[4:3], exp_out[4:3]});
            check(aclink_sdi1_o == sv[1] && adc1_sdin1_o == !sv[1], "R5 routing",
                  {aclink_sdi1_o, adc1_sdin1_o}, {sv[1], !sv[1]});
            cfg_func_i = 7'h40;
            #1;
            check(cfg_pin_o[6] == !sv[6], "R6 cs before edge", cfg_pin_o[6], !sv[6]);
            check(cfg_pin_o[5:0] == 6'h00, "R6 direct bits", cfg_pin_o[5:0], 0);
            @(negedge clk);
            check(cfg_pin_o[6] == 1'b1, "R6 cs after edge", cfg_pin_o[6], 1);
            cfg_func_i = 7'h00;
            check(strap_o == sv, "R2 hold", strap_o, sv);
        end

        // R7 defaults with all bits general-purpose
        alt_oe_i = '0;
        alt_out_i = '0;
        do_reset(7'b0000100, 3'b010);
        check(gpio_pin_oe == 9'h0AB, "R7 default dir", gpio_pin_oe, 9'h0AB);
        check(gpio_pin_o == 9'h000, "R7 default out", gpio_pin_o, 0);

        // R8 writes on free bits
        wr(2'd0, 9'h1FF);
        wr(2'd1, 9'h155);
        check(gpio_pin_oe == 9'h1FF, "R8 dir write", gpio_pin_oe, 9'h1FF);
        check(gpio_pin_o == 9'h155, "R8 out write", gpio_pin_o, 9'h155);
        wr(2'd0, 9'h00F);
        check(gpio_pin_oe == 9'h00F, "R8 dir rewrite", gpio_pin_oe, 9'h00F);

        // R8 writes on owned bits are ignored
        do_reset(7'b0000001, 3'b000);
        wr(2'd0, 9'h1FF);
        wr(2'd1, 9'h1FF);
        check(gpio_pin_oe == 9'h007, "R8 masked dir", gpio_pin_oe, 9'h007);
        check(gpio_pin_o == 9'h007, "R8 masked out", gpio_pin_o, 9'h007);

        // R9 synchroniser
        gpio_pin_i = 9'h1A5;
        @(negedge clk);
        check(gpio_rd_o == 9'h000, "R9 one edge", gpio_rd_o, 0);
        @(negedge clk);
        check(gpio_rd_o == 9'h1A5, "R9 two edges", gpio_rd_o, 9'h1A5);
        gpio_pin_i = 9'h05A;
        @(negedge clk);
        @(negedge clk);
        check(gpio_rd_o == 9'h05A, "R9 second pattern", gpio_rd_o, 9'h05A);

        // R10 codec reset polarity
        codec_rst_req_i = 1'b1;
        #1;
        check(codec_rst_pin_o == 1'b0, "R10 active low", codec_rst_pin_o, 0);
        wr(2'd2, 9'h001);
        check(codec_rst_pin_o == 1'b1, "R10 active high", codec_rst_pin_o, 1);
        codec_rst_req_i = 1'b0;
        #1;
        check(codec_rst_pin_o == 1'b0, "R10 idle high pol", codec_rst_pin_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule